// File: doc/BRIEF.md
# XOR-Differential Serializer Link Codec

This block is the two ends of a narrow on-chip serial link, built as one unit. The transmit end accepts a W-bit parallel word through a valid/ready handshake. It XORs the word, bit by bit, with the raw word it accepted before, and it shifts the result onto a single line, most significant bit first, one bit per clock. A one-clock start marker runs alongside the line and flags the first bit of each word.

The receive end watches the line and the marker. It gathers W bits into a word and XORs that word with the word it decoded last, which restores the original data. It then presents the result as a parallel word with a one-clock valid pulse. When successive words are close to one another, the coded words are mostly zeros. This cuts both the number of ones sent and the number of toggles on the line.

The two history registers, one at each end, clear on the same reset. The first word after reset therefore travels unchanged. The line and the marker come out as ports so the serial traffic can be observed. Clock recovery and the electrical behaviour of the line are outside this block.

Transmit states: `TX_IDLE` (nothing shifting, ready high) and `TX_SHIFT` (a word is on the line). Transitions: `TX_IDLE`→`TX_SHIFT` on a handshake. `TX_SHIFT`→`TX_IDLE` on the last bit when no new word arrives. `TX_SHIFT`→`TX_SHIFT` on the last bit when a new word is accepted back-to-back. Receive states: `RX_HUNT` (waiting for a marker) and `RX_GATHER` (collecting bits). Transitions: `RX_HUNT`→`RX_GATHER` on a marker. `RX_GATHER`→`RX_HUNT` after the W-th bit. `RX_GATHER`→`RX_GATHER` restarting at bit one if a marker arrives early.

Top module: `xdl_link_codec`

## Requirements
- R1: The first word accepted after reset goes onto the line unchanged, because the transmit history starts at zero.
- R2: Each coded word on the line equals the accepted word XOR the raw word accepted just before it.
- R3: A coded word is sent one bit per clock, bit W-1 first and bit 0 last, over exactly W consecutive cycles. The first bit appears in the cycle right after the accepting clock edge.
- R4: `line_start` is high in the cycle of bit W-1 of each word and low in every other cycle.
- R5: `in_ready` is high when no word is shifting and during the last bit of a word, and low otherwise. A word is accepted at a clock edge where `in_valid` and `in_ready` are both high, so words can follow one another with no idle cycle.
- R6: When no word is shifting, `line_bit` is 0.
- R7: `out_valid` pulses high for one cycle, in the cycle after the last bit of each word. In that cycle `out_word` equals the word that was accepted, in order.
- R8: While reset is asserted and right after it, `in_ready` is 1 and `line_start`, `line_bit` and `out_valid` are 0. Reset clears both history registers together, so later words still decode correctly.
- R9: With W=8, the accepted words 0x51, 0x52, 0x53, 0x54, 0x55 go onto the line as 0x51, 0x03, 0x01, 0x07, 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | W | Parallel word to send |
| in_valid | input | 1 | `in_word` holds a word to send |
| in_ready | output | 1 | Transmit end can take a word at this edge |
| line_bit | output | 1 | Serial line carrying the coded bits |
| line_start | output | 1 | Marks the first serial bit of each word |
| out_word | output | W | Decoded parallel word |
| out_valid | output | 1 | One-cycle strobe for `out_word` |

## Verification
The bench builds the codec at the default W=8. At that width the five-word sequence from R9 can be checked bit for bit on the line, and a byte-wide random sweep reaches words that differ in many bit positions as well as runs of identical words, whose coded value is zero. With eight bits per word there are seven cycles in which the transmit end must hold `in_ready` low and one last-bit cycle in which it must raise it. Back-to-back and gapped traffic therefore both test the handshake timing. A second reset in the middle of the run shows that the two history registers clear together.

// File: rtl/xdl_pkg.sv
package xdl_pkg;
    typedef enum logic {
        TX_IDLE,
        TX_SHIFT
    } tx_state_e;

    typedef enum logic {
        RX_HUNT,
        RX_GATHER
    } rx_state_e;
endpackage

// File: rtl/xdl_xor_lane.sv
// Bitwise differential combiner shared by both link ends.
module xdl_xor_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_word,
    input  logic [W-1:0] hist_word,
    output logic [W-1:0] mix_word
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        assign mix_word[i] = cur_word[i] ^ hist_word[i];
    end
endmodule

// File: rtl/xdl_tx.sv
// Transmit end: differential coding against the last raw word, then MSB-first shift.
module xdl_tx
    import xdl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_word,
    input  logic         in_valid,
    output logic         in_ready,
    output logic         ser_bit,
    output logic         ser_start
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    tx_state_e     state_q, state_d;
    logic [CW-1:0] bit_idx_q;
    logic [W-1:0]  shift_q;
    logic [W-1:0]  raw_hist_q;
    logic [W-1:0]  coded;
    logic          on_last;
    logic          take;

    xdl_xor_lane #(.W(W)) u_enc (
        .cur_word  (in_word),
        .hist_word (raw_hist_q),
        .mix_word  (coded)
    );

    assign on_last = (state_q == TX_SHIFT) && (bit_idx_q == LAST_IDX);
    assign take    = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (take) state_d = TX_SHIFT;
            TX_SHIFT: if (on_last && !take) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx_q  <= '0;
            shift_q    <= '0;
            raw_hist_q <= '0;
        end else if (take) begin
            bit_idx_q  <= '0;
            shift_q    <= coded;
            raw_hist_q <= in_word;
        end else if (state_q == TX_SHIFT) begin
            bit_idx_q  <= on_last ? '0 : bit_idx_q + 1'b1;
            shift_q    <= {shift_q[W-2:0], 1'b0};
        end
    end

    always_comb begin
        in_ready  = 1'b0;
        ser_bit   = 1'b0;
        ser_start = 1'b0;
        unique case (state_q)
            TX_IDLE: in_ready = 1'b1;
            TX_SHIFT: begin
                in_ready  = on_last;
                ser_bit   = shift_q[W-1];
                ser_start = (bit_idx_q == '0);
            end
            default: in_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/xdl_rx.sv
// Receive end: marker-aligned deserializer, then XOR with last decoded word.
module xdl_rx
    import xdl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_bit,
    input  logic         ser_start,
    output logic [W-1:0] out_word,
    output logic         out_valid
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    rx_state_e     state_q, state_d;
    logic [CW-1:0] got_q;
    logic [W-1:0]  gather_q;
    logic [W-1:0]  dec_hist_q;
    logic [W-1:0]  full_word;
    logic [W-1:0]  plain;
    logic          word_done;
    logic [W-1:0]  word_q;
    logic          strobe_q;

    assign full_word = {gather_q[W-2:0], ser_bit};
    assign word_done = (state_q == RX_GATHER) && !ser_start && (got_q == LAST_IDX);

    xdl_xor_lane #(.W(W)) u_dec (
        .cur_word  (full_word),
        .hist_word (dec_hist_q),
        .mix_word  (plain)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HUNT:   if (ser_start) state_d = RX_GATHER;
            RX_GATHER: if (word_done) state_d = RX_HUNT;
            default:   state_d = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            got_q      <= '0;
            gather_q   <= '0;
            dec_hist_q <= '0;
            word_q     <= '0;
            strobe_q   <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (ser_start) begin
                got_q    <= CW'(1);
                gather_q <= full_word;
            end else if (state_q == RX_GATHER) begin
                gather_q <= full_word;
                if (word_done) begin
                    got_q      <= '0;
                    dec_hist_q <= plain;
                    word_q     <= plain;
                    strobe_q   <= 1'b1;
                end else begin
                    got_q <= got_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        out_word  = word_q;
        out_valid = strobe_q;
    end
endmodule

// File: rtl/xdl_link_codec.sv
module xdl_link_codec #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_word,
    input  logic         in_valid,
    output logic         in_ready,
    output logic         line_bit,
    output logic         line_start,
    output logic [W-1:0] out_word,
    output logic         out_valid
);
    xdl_tx #(.W(W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_word   (in_word),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .ser_bit   (line_bit),
        .ser_start (line_start)
    );

    xdl_rx #(.W(W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_bit   (line_bit),
        .ser_start (line_start),
        .out_word  (out_word),
        .out_valid (out_valid)
    );
endmodule

// File: rtl/xdl_link_chk.sv
module xdl_link_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic         line_bit,
    input logic         line_start,
    input logic         out_valid
);
    localparam int PW = $clog2(W) + 1;
    localparam logic [PW-1:0] LASTP = PW'(W - 1);

    logic [PW-1:0] pos_q;
    logic          last_d_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q    <= '0;
            last_d_q <= 1'b0;
        end else begin
            last_d_q <= (pos_q == LASTP);
            if (line_start)                             pos_q <= PW'(1);
            else if (pos_q != '0 && pos_q != LASTP)     pos_q <= pos_q + 1'b1;
            else                                        pos_q <= '0;
        end
    end

    assert_marker_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> (pos_q == '0));
    assert_marker_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !line_start);
    assert_busy_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start || (pos_q != '0 && pos_q != LASTP)) |-> !in_ready);
    assert_take_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> line_start);
    assert_idle_line_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && pos_q == '0) |-> !line_bit);
    assert_strobe_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> last_d_q);
    assert_last_gives_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_d_q |-> out_valid);
endmodule

bind xdl_link_codec xdl_link_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .line_bit   (line_bit),
    .line_start (line_start),
    .out_valid  (out_valid)
);

// File: tb/xdl_link_codec_tb_top.sv
`timescale 1ns/1ps
module xdl_link_codec_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_word = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         line_bit;
    logic         line_start;
    logic [W-1:0] out_word;
    logic         out_valid;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    xdl_link_codec #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .in_ready(in_ready), .line_bit(line_bit), .line_start(line_start),
        .out_word(out_word), .out_valid(out_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, evaluated every cycle away from the edge.
    int           qb[$];
    int           qs[$];
    int           ql[$];
    int           exp_words[$];
    int           seen_enc[$];
    logic [W-1:0] m_prev = '0;
    logic [W-1:0] cur_enc = '0;
    bit           pend = 0;
    int           pend_word = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            qb.delete(); qs.delete(); ql.delete(); exp_words.delete();
            m_prev = '0; pend = 0;
            chk(in_ready == 1'b1,   "R8 ready in reset", int'(in_ready), 1);
            chk(line_start == 1'b0, "R8 marker in reset", int'(line_start), 0);
            chk(line_bit == 1'b0,   "R8 line in reset", int'(line_bit), 0);
            chk(out_valid == 1'b0,  "R8 strobe in reset", int'(out_valid), 0);
        end else begin
            bit exp_ready;
            chk(out_valid == pend, "R7 strobe timing", int'(out_valid), int'(pend));
            if (pend)
                chk(int'(out_word) == pend_word, "R7 decoded word", int'(out_word), pend_word);
            pend = 0;
            exp_ready = (qb.size() <= 1);
            chk(in_ready == exp_ready, "R5 ready", int'(in_ready), int'(exp_ready));
            if (qb.size() > 0) begin
                int b, s, l;
                b = qb.pop_front(); s = qs.pop_front(); l = ql.pop_front();
                chk(int'(line_bit) == b, "R3 serial bit (R2 coding)", int'(line_bit), b);
                chk(int'(line_start) == s, "R4 marker", int'(line_start), s);
                cur_enc = {cur_enc[W-2:0], line_bit};
                if (l != 0) begin
                    pend = 1;
                    pend_word = exp_words.pop_front();
                    seen_enc.push_back(int'(cur_enc));
                end
            end else begin
                chk(line_bit == 1'b0,   "R6 idle line", int'(line_bit), 0);
                chk(line_start == 1'b0, "R4 idle marker", int'(line_start), 0);
            end
            if (in_valid && exp_ready) begin
                logic [W-1:0] enc;
                enc = in_word ^ m_prev;
                m_prev = in_word;
                exp_words.push_back(int'(in_word));
                for (int i = W - 1; i >= 0; i--) begin
                    qb.push_back(int'(enc[i]));
                    qs.push_back((i == W - 1) ? 1 : 0);
                    ql.push_back((i == 0) ? 1 : 0);
                end
            end
        end
    end

    task automatic send(input logic [W-1:0] w);
        in_valid = 1'b1;
        in_word  = w;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        #1;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [W-1:0] ex_enc [5];
        logic [W-1:0] w;
        ex_enc[0] = 8'h51; ex_enc[1] = 8'h03; ex_enc[2] = 8'h01;
        ex_enc[3] = 8'h07; ex_enc[4] = 8'h01;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R9 / R1: worked example, back-to-back
        seen_enc.delete();
        for (int i = 0; i < 5; i++) send(8'h51 + 8'(i));
        idle(W + 3);
        chk(seen_enc.size() == 5, "R9 word count", seen_enc.size(), 5);
        for (int i = 0; i < 5 && i < seen_enc.size(); i++)
            chk(seen_enc[i] == int'(ex_enc[i]), "R9 coded word", seen_enc[i], int'(ex_enc[i]));
        if (seen_enc.size() > 0)
            chk(seen_enc[0] == 8'h51, "R1 first word unchanged", seen_enc[0], 8'h51);

        // R2: repeated words code to zero
        seen_enc.delete();
        send(8'h3C); send(8'h3C); send(8'h3C);
        idle(W + 3);
        if (seen_enc.size() == 3) begin
            chk(seen_enc[0] == (8'h3C ^ 8'h55), "R2 coded vs previous", seen_enc[0], 8'h3C ^ 8'h55);
            chk(seen_enc[1] == 0, "R2 repeat codes zero", seen_enc[1], 0);
            chk(seen_enc[2] == 0, "R2 repeat codes zero", seen_enc[2], 0);
        end else chk(0, "R2 word count", seen_enc.size(), 3);

        // Alternating extremes, back-to-back
        send(8'hFF); send(8'h00); send(8'hAA); send(8'h55);
        idle(W + 3);

        // Random words with random gaps (R3, R5, R7)
        for (int i = 0; i < 40; i++) begin
            w = 8'($urandom);
            send(w);
            idle(int'($urandom % 4) * (W / 2));
        end
        idle(W + 3);

        // R8 / R1: reset between words clears both histories together
        do_reset();
        idle(2);
        seen_enc.delete();
        send(8'hA5); send(8'hA4);
        idle(W + 3);
        if (seen_enc.size() == 2) begin
            chk(seen_enc[0] == 8'hA5, "R1 first word after reset", seen_enc[0], 8'hA5);
            chk(seen_enc[1] == 8'h01, "R8 coding after reset", seen_enc[1], 8'h01);
        end else chk(0, "R8 word count", seen_enc.size(), 2);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule